// File: doc/BRIEF.md
# ACPI Event Status/Enable Register Block

This block holds the event status and event enable registers of a power-management event group, reached through byte-wide I/O reads and writes. Hardware event sources pulse `evt_pulse` for one cycle. Each pulse latches a sticky status bit, which software later clears by writing a one to it. When a latched status bit meets a set enable bit in the same position, the block raises the system control interrupt `sci`. This is a level that stays high until the overlap goes away.

The I/O window starts at a 16-bit base address built from two configuration bytes (`cfg_base_hi`:`cfg_base_lo`). It covers four byte offsets, in this order:

- status low
- status high
- enable low
- enable high

Addresses outside the window are not claimed. Only three status bits exist: timer (bit 0), bus master (bit 4) and global (bit 5). Only the timer and global bits have enable bits. The bus-master bit can be read and cleared, but it never raises the interrupt.

The interrupt is produced by a two-state machine:

- **SCI_QUIET**: the output is low. It moves to SCI_RAISED (transition *raise*) on any cycle in which a status bit and its enable bit are both set.
- **SCI_RAISED**: the output is high. It returns to SCI_QUIET (transition *drop*) on the first cycle with no such overlap.

Top module: `pm_evt_regblk`

## Requirements
- R1: An access with `io_rd` or `io_wr` high is claimed (`io_hit`=1) only when `io_addr` minus the base `{cfg_base_hi,cfg_base_lo}` is 0, 1, 2 or 3. The offsets select status[7:0], status[15:8], enable[7:0] and enable[15:8] in that order. An unclaimed read returns `io_rdata`=00h, and an unclaimed write changes no register.
- R2: A one-cycle high on `evt_pulse[i]`, for an implemented status bit i, sets status bit i at the next clock edge. The bit then stays set until software clears it.
- R3: A write to a status byte clears every bit written as 1 and leaves every bit written as 0 unchanged. A write never sets a status bit.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Only status bits 0 (timer), 4 (bus master) and 5 (global) are implemented. All other status bits always read 0, whatever the events or writes.
- R6: Enable bits 0 and 5 can be written and read back. All other enable bits always read 0, and writes to them are ignored.
- R7: `sci` goes high one clock after status bit i and enable bit i are both set (i = 0 or 5). Status bit 4 never raises `sci`.
- R8: `sci` goes low one clock after the last overlapping status/enable pair is removed, whether by clearing the status bit or the enable bit.
- R9: After reset, all status and enable bits are 0 and `sci` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_hi | input | 8 | High byte of I/O base address |
| cfg_base_lo | input | 8 | Low byte of I/O base address |
| io_addr | input | 16 | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte (combinational, 00h when not claimed) |
| io_hit | output | 1 | Access falls inside the four-byte window |
| evt_pulse | input | 16 | Hardware event pulses, one per status bit |
| sci | output | 1 | System control interrupt, active-high level |

## Verification
The bench sets an event and clears it in the same cycle, and expects the bit to survive. A design that lets the clear win would silently lose a wake event. It writes 00h and then FFh to status bytes: writing zero must not clear anything, and writing ones to a cleared register must not set anything. It also pulses all sixteen event lines at once with every enable written, to catch reserved bits that leak into the readback or a bus-master bit that raises the interrupt. Finally, it measures the one-cycle lag of `sci` when the interrupt rises, when it falls after a status clear and when it falls after an enable clear. It also probes addresses just outside the window and after a base move, to catch off-by-one decoding and a stale base address.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    // States of the interrupt output machine
    typedef enum logic [0:0] {
        SCI_QUIET  = 1'b0,
        SCI_RAISED = 1'b1
    } sci_state_e;

    // Which register of the status/enable pair an access selects
    typedef enum logic [0:0] {
        REG_STS = 1'b0,
        REG_EN  = 1'b1
    } reg_kind_e;

endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
    import pm_evt_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic [BYTE_W-1:0] cfg_hi,
    input  logic [BYTE_W-1:0] cfg_lo,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic              hit,
    output reg_kind_e         kind,
    output logic [LANES-1:0]  lane_oh
);
    localparam int unsigned NUM_OFF = 2 * LANES;
    localparam int unsigned OFF_W   = $clog2(NUM_OFF);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    logic [OFF_W-1:0]  idx;
    logic [OFF_W-1:0]  lane_idx;
    logic              in_range;

    assign base     = {cfg_hi, cfg_lo};
    assign off      = io_addr - base;
    assign in_range = (off < ADDR_W'(NUM_OFF));
    assign hit      = (io_rd | io_wr) & in_range;
    assign idx      = off[OFF_W-1:0];
    assign kind     = (idx >= OFF_W'(LANES)) ? REG_EN : REG_STS;
    assign lane_idx = (kind == REG_EN) ? (idx - OFF_W'(LANES)) : idx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_oh[l] = hit & (lane_idx == OFF_W'(l));
    end
endmodule

// File: rtl/pm_evt_bits.sv
module pm_evt_bits #(
    parameter int unsigned       REG_W     = 16,
    parameter int unsigned       BYTE_W    = 8,
    parameter logic [REG_W-1:0]  IMPL_MASK = 16'h0031,
    parameter bit                STICKY    = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [REG_W/BYTE_W-1:0]   wr_lane,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic [REG_W-1:0]          set_evt,
    output logic [REG_W-1:0]          q
);
    localparam int unsigned LANES = REG_W / BYTE_W;

    logic [REG_W-1:0] wstrb;
    logic [REG_W-1:0] wfull;
    logic [REG_W-1:0] nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wstrb[l*BYTE_W +: BYTE_W] = {BYTE_W{wr_lane[l]}};
        assign wfull[l*BYTE_W +: BYTE_W] = wdata;
    end

    if (STICKY) begin : g_w1c
        // Ones clear; hardware set is applied last so an event wins
        assign nxt = ((q & ~(wstrb & wfull)) | set_evt) & IMPL_MASK;
    end else begin : g_rw
        assign nxt = ((q & ~wstrb) | (wfull & wstrb) | set_evt) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/pm_evt_sci_fsm.sv
module pm_evt_sci_fsm
    import pm_evt_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sts,
    input  logic [REG_W-1:0] en,
    output logic             sci
);
    sci_state_e state_q, state_d;
    logic       pend;

    assign pend = |(sts & en);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCI_QUIET:  if (pend)  state_d = SCI_RAISED;   // raise
            SCI_RAISED: if (!pend) state_d = SCI_QUIET;    // drop
            default:               state_d = SCI_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCI_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        sci = (state_q == SCI_RAISED);
    end
endmodule

// File: rtl/pm_evt_regblk.sv
module pm_evt_regblk
    import pm_evt_pkg::*;
#(
    parameter int unsigned      REG_W    = 16,
    parameter int unsigned      BYTE_W   = 8,
    parameter logic [REG_W-1:0] STS_MASK = 16'h0031,
    parameter logic [REG_W-1:0] EN_MASK  = 16'h0021
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   cfg_base_hi,
    input  logic [BYTE_W-1:0]   cfg_base_lo,
    input  logic [2*BYTE_W-1:0] io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [BYTE_W-1:0]   io_wdata,
    output logic [BYTE_W-1:0]   io_rdata,
    output logic                io_hit,
    input  logic [REG_W-1:0]    evt_pulse,
    output logic                sci
);
    localparam int unsigned LANES  = REG_W / BYTE_W;
    localparam int unsigned ADDR_W = 2 * BYTE_W;

    reg_kind_e        kind;
    logic [LANES-1:0] lane_oh;
    logic [LANES-1:0] sts_wr;
    logic [LANES-1:0] en_wr;
    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;

    pm_evt_decode #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_dec (
        .cfg_hi  (cfg_base_hi),
        .cfg_lo  (cfg_base_lo),
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .hit     (io_hit),
        .kind    (kind),
        .lane_oh (lane_oh)
    );

    assign sts_wr = lane_oh & {LANES{io_wr & (kind == REG_STS)}};
    assign en_wr  = lane_oh & {LANES{io_wr & (kind == REG_EN)}};

    pm_evt_bits #(
        .REG_W     (REG_W),
        .BYTE_W    (BYTE_W),
        .IMPL_MASK (STS_MASK),
        .STICKY    (1'b1)
    ) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (sts_wr),
        .wdata   (io_wdata),
        .set_evt (evt_pulse),
        .q       (sts_q)
    );

    pm_evt_bits #(
        .REG_W     (REG_W),
        .BYTE_W    (BYTE_W),
        .IMPL_MASK (EN_MASK),
        .STICKY    (1'b0)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lane (en_wr),
        .wdata   (io_wdata),
        .set_evt ('0),
        .q       (en_q)
    );

    always_comb begin
        io_rdata = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            if (io_rd && lane_oh[l]) begin
                io_rdata = (kind == REG_EN) ? en_q[l*BYTE_W +: BYTE_W]
                                            : sts_q[l*BYTE_W +: BYTE_W];
            end
        end
    end

    pm_evt_sci_fsm #(
        .REG_W (REG_W)
    ) u_sci (
        .clk   (clk),
        .rst_n (rst_n),
        .sts   (sts_q),
        .en    (en_q),
        .sci   (sci)
    );
endmodule

// File: rtl/pm_evt_regblk_chk.sv
module pm_evt_regblk_chk #(
    parameter logic [15:0] STS_MASK = 16'h0031,
    parameter logic [15:0] EN_MASK  = 16'h0021
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cfg_hi,
    input logic [7:0]  cfg_lo,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic        io_hit,
    input logic [15:0] evt_pulse,
    input logic [15:0] sts,
    input logic [15:0] en,
    input logic        sci
);
    logic [15:0] base;
    assign base = {cfg_hi, cfg_lo};

    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> ((io_rd || io_wr) && ((io_addr - base) < 16'd4)));                     // R1

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~$past(sts) & ~$past(evt_pulse)) == 16'h0000));                            // R3

    AST_W1C_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_hit && (io_addr == base))
        |=> ((sts[7:0] & $past(io_wdata & ~evt_pulse[7:0])) == 8'h00));                    // R3

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & STS_MASK) != 16'h0000)
        |=> ((sts & $past(evt_pulse & STS_MASK)) == $past(evt_pulse & STS_MASK)));        // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (((sts & ~STS_MASK) | (en & ~EN_MASK)) == 16'h0000));                               // R5

    AST_SCI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts & en)) |=> sci);                                                             // R7

    AST_SCI_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts & en)) |=> !sci);                                                           // R8
endmodule

bind pm_evt_regblk pm_evt_regblk_chk #(
    .STS_MASK (STS_MASK),
    .EN_MASK  (EN_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_hi    (cfg_base_hi),
    .cfg_lo    (cfg_base_lo),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_hit    (io_hit),
    .evt_pulse (evt_pulse),
    .sts       (sts_q),
    .en        (en_q),
    .sci       (sci)
);

// File: tb/pm_evt_regblk_tb.sv
module pm_evt_regblk_tb;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_base_hi = 8'h0C;
    logic [7:0]  cfg_base_lo = 8'h80;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic [15:0] evt_pulse = '0;
    logic        sci;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       hit;
        string      req;
    } item_t;
    item_t exp_q[$];

    always #(CLK_T/2) clk = ~clk;

    pm_evt_regblk u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_base_hi (cfg_base_hi),
        .cfg_base_lo (cfg_base_lo),
        .io_addr     (io_addr),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_hit      (io_hit),
        .evt_pulse   (evt_pulse),
        .sci         (sci)
    );

    // Monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        if (io_rd) begin
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL read without expectation addr=%h", io_addr);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (io_rdata !== it.data || io_hit !== it.hit) begin
                    n_bad++;
                    $display("FAIL %s addr=%h: got data=%h hit=%b, expected data=%h hit=%b",
                             it.req, io_addr, io_rdata, io_hit, it.data, it.hit);
                end
            end
        end
    end

    function automatic logic [15:0] base();
        return {cfg_base_hi, cfg_base_lo};
    endfunction

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [15:0] addr, input logic [7:0] exp,
                      input logic exp_hit, input string req);
        item_t it;
        @(posedge clk); #1;
        io_addr = addr; io_rd = 1'b1;
        it.data = exp; it.hit = exp_hit; it.req = req;
        exp_q.push_back(it);
        @(negedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic wr_evt(input logic [1:0] off, input logic [7:0] d, input logic [15:0] ev);
        @(posedge clk); #1;
        io_addr = base() + 16'(off); io_wdata = d; io_wr = 1'b1; evt_pulse = ev;
        @(posedge clk); #1;
        io_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        wr_evt(off, d, 16'h0000);
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(posedge clk); #1;
        evt_pulse = ev;
        @(posedge clk); #1;
        evt_pulse = '0;
    endtask

    task automatic chk_sci(input logic exp, input string req);
        @(negedge clk);
        n_cmp++;
        if (sci !== exp) begin
            n_bad++;
            $display("FAIL %s sci: got %b, expected %b", req, sci, exp);
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state
        rd(base() + 16'd0, 8'h00, 1'b1, "R9");
        rd(base() + 16'd1, 8'h00, 1'b1, "R9");
        rd(base() + 16'd2, 8'h00, 1'b1, "R9");
        rd(base() + 16'd3, 8'h00, 1'b1, "R9");
        chk_sci(1'b0, "R9");

        // R2 R5: all events at once; only bits 0,4,5 latch
        pulse(16'hFFFF);
        rd(base() + 16'd0, 8'h31, 1'b1, "R2");
        rd(base() + 16'd1, 8'h00, 1'b1, "R5");
        chk_sci(1'b0, "R7");   // enables still clear

        // R6 enable implemented bits only
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(base() + 16'd2, 8'h21, 1'b1, "R6");
        rd(base() + 16'd3, 8'h00, 1'b1, "R6");
        idle();
        chk_sci(1'b1, "R7");

        // R3 writing zero changes nothing; ones clear per bit
        wr(2'd0, 8'h00);
        rd(base() + 16'd0, 8'h31, 1'b1, "R3");
        wr(2'd0, 8'h01);
        rd(base() + 16'd0, 8'h30, 1'b1, "R3");
        chk_sci(1'b1, "R7");
        wr(2'd0, 8'h20);
        chk_sci(1'b1, "R8");   // one-cycle lag after clear
        idle();
        chk_sci(1'b0, "R8");
        rd(base() + 16'd0, 8'h10, 1'b1, "R7");  // bus-master bit left, no sci
        chk_sci(1'b0, "R7");
        wr(2'd0, 8'hFF);
        wr(2'd0, 8'hFF);
        rd(base() + 16'd0, 8'h00, 1'b1, "R3");   // ones never set

        // R7 rise timing from timer event
        pulse(16'h0001);
        chk_sci(1'b0, "R7");
        idle();
        chk_sci(1'b1, "R7");

        // R8 drop by clearing enable
        wr(2'd2, 8'h00);
        chk_sci(1'b1, "R8");
        idle();
        chk_sci(1'b0, "R8");
        rd(base() + 16'd0, 8'h01, 1'b1, "R2");  // status stays sticky

        // R4 event wins over same-cycle clear
        pulse(16'h0020);
        wr_evt(2'd0, 8'h21, 16'h0001);
        rd(base() + 16'd0, 8'h01, 1'b1, "R4");

        // R1 window edges
        rd(base() + 16'd4, 8'h00, 1'b0, "R1");
        rd(base() - 16'd1, 8'h00, 1'b0, "R1");
        @(posedge clk); #1;
        io_addr = base() + 16'd4; io_wdata = 8'hFF; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
        rd(base() + 16'd0, 8'h01, 1'b1, "R1");
        rd(base() + 16'd2, 8'h00, 1'b1, "R1");

        // R1 base move
        cfg_base_hi = 8'h03; cfg_base_lo = 8'h10;
        rd(16'h0C80, 8'h00, 1'b0, "R1");
        rd(16'h0310, 8'h01, 1'b1, "R1");
        rd(16'h0313, 8'h00, 1'b1, "R1");

        idle();
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 %0d expected reads never observed, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule